// File: doc/BRIEF.md
# Transactional Packet FIFO with Rollback

This block is a byte-wide packet buffer that sits between a bus-side packet writer and a frame-side packet reader. Both sides work in transactions. The writer streams the bytes of one bus packet into storage without making them visible. The packet is published when its last byte arrives, or thrown away by rewinding the write pointer when the packet was flagged bad or did not fit. The reader fetches bytes ahead of a committed read head while it transmits. It then either acknowledges the transfer, which releases the storage, or reports a failed handshake, which rewinds the fetch pointer so the same bytes can be sent again.

Each stored byte carries two markers: one for the end of a bus packet and one for the end of an Ethernet frame. A mode input selects how frames map onto bus packets. With one frame per bus packet, the frame marker is simply the packet end. In packed mode, the writer may also mark frame boundaries inside a bus packet. Free space is always measured against the committed read head, so bytes that have been sent but not yet acknowledged are never overwritten.

Top module: `pkt_txn_fifo`

## Requirements
- R1: After a synchronous active-low reset, `fill_level` is 0, `free_space` equals DEPTH and `rd_valid` is 0.
- R2: The bytes of a committed packet come out in write order. `rd_last` is 1 on the final byte only. The packet becomes readable in the cycle after the clock edge that takes its last byte (`wr_valid` and `wr_last` both high).
- R3: Bytes of a packet whose last byte has not yet been taken are never readable. `rd_valid` is 1 only while committed bytes lie beyond the read fetch pointer.
- R4: A packet in which `wr_err` is high on any beat, including the last one, is discarded as a whole. The write pointer returns to the packet's start, `fill_level` is unchanged, and none of its bytes is ever read.
- R5: A byte that arrives when the speculative write pointer is DEPTH bytes ahead of the committed read head marks the packet as overflowed, and the whole packet is discarded at its end. A packet that exactly fills the remaining space is kept, and `free_space` then reads 0.
- R6: `rd_ack` (without `rd_nack`) moves the committed read head to the fetch pointer. `fill_level` and `free_space` change by the number of bytes fetched since the last ack or nack. Without an ack the head does not move.
- R7: `rd_nack` reloads the fetch pointer from the committed read head. The next bytes read repeat the packet byte for byte from its first unacknowledged byte, and `fill_level` is unchanged.
- R8: `free_space` equals DEPTH minus the bytes between the committed read head and the speculative write pointer. Bytes that have been fetched but not acknowledged keep their space, and a packet that needs that space is discarded.
- R9: With `pack_mode` = 0 (one frame per bus packet), `rd_frame_end` equals `rd_last` on every byte, and `wr_frame_end` has no effect.
- R10: With `pack_mode` = 1 (several frames per bus packet), `rd_frame_end` is 1 on each byte written with `wr_frame_end` = 1 and on each packet's last byte.
- R11: When `rd_ack` and `rd_nack` are high in the same cycle, the nack wins: the head stays where it is and the fetch pointer rewinds to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pack_mode | input | 1 | 0: one frame per bus packet, 1: several frames per bus packet |
| wr_valid | input | 1 | A write byte is present this cycle |
| wr_data | input | 8 | Write byte |
| wr_last | input | 1 | This byte ends the bus packet (commit point) |
| wr_err | input | 1 | The current packet is erroneous and must be dropped |
| wr_frame_end | input | 1 | This byte ends a frame (packed mode only) |
| rd_ready | input | 1 | The reader takes the presented byte |
| rd_ack | input | 1 | The transfer read so far is delivered; release it |
| rd_nack | input | 1 | The handshake failed; rewind to the committed head |
| rd_valid | output | 1 | A committed byte is presented |
| rd_data | output | 8 | Presented byte |
| rd_last | output | 1 | The presented byte ends a bus packet |
| rd_frame_end | output | 1 | The presented byte ends a frame |
| fill_level | output | $clog2(DEPTH)+1 | Committed bytes not yet acknowledged |
| free_space | output | $clog2(DEPTH)+1 | Space left for the writer |

## Verification
The bench runs a 16-byte configuration. It sweeps clean packets of every length from 1 to the full depth. Each one is read partway, rewound, read again and acknowledged, which separates a correct rewind from a fetch pointer that keeps going or a head that moves too early. A second sweep puts the error flag on every beat position of short packets. This separates a drop on the last beat from a drop on an earlier beat. Packets that are oversized, exactly full, or blocked only by unacknowledged bytes check the space accounting at its edges. Packets whose frame markers are set on chosen bytes, run in both modes, show whether the marker is forced to the packet end or passed through.

// File: rtl/ptx_pkg.sv
// Package: shared entry layout for the transactional packet FIFO.
// Assumes byte-wide payload; each stored entry adds two boundary markers.
package ptx_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic              pkt_end;   // closes a bus packet
        logic              frm_end;   // closes a frame
        logic [BYTE_W-1:0] data;
    } ptx_entry_t;

    localparam int ENTRY_W = $bits(ptx_entry_t);
endpackage

// File: rtl/ptx_store.sv
// Module: entry storage with one synchronous write port and one
// combinational read port. Assumes DEPTH is a power of two.
// Contents are not reset; readers qualify data with their own valid.
module ptx_store #(
    parameter  int DEPTH = 2048,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        we,
    input  logic [AW-1:0]               waddr,
    input  ptx_pkg::ptx_entry_t         wdata,
    input  logic [AW-1:0]               raddr,
    output ptx_pkg::ptx_entry_t         rdata
);
    ptx_pkg::ptx_entry_t mem [DEPTH];

    // Purpose: store one entry per accepted write beat.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ptx_wr_ctrl.sv
// Module: write-side transaction control. Keeps a speculative and a
// committed write pointer (one extra wrap bit each). A packet commits on
// its last beat unless it was flagged bad or overflowed; otherwise the
// speculative pointer rolls back to the committed one.
// Assumes: rd_head is the committed read head from the read side.
module ptx_wr_ctrl #(
    parameter  int DEPTH = 2048,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic          wr_last,
    input  logic          wr_err,
    input  logic [PW-1:0] rd_head,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [PW-1:0] spec_ptr,
    output logic [PW-1:0] cmt_ptr,
    output logic [PW-1:0] free_cnt
);
    localparam logic [PW-1:0] CAP = PW'(DEPTH);

    logic [PW-1:0] spec_q, cmt_q;
    logic          bad_q;
    logic [PW-1:0] used;
    logic          room;
    logic          commit_ok;

    // Purpose: space accounting against the committed read head.
    always_comb begin
        used      = spec_q - rd_head;
        room      = (used != CAP);
        free_cnt  = CAP - used;
        we        = wr_valid && room && !bad_q;
        commit_ok = wr_valid && wr_last && room && !bad_q && !wr_err;
    end

    // Purpose: advance, commit or roll back the write pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_q <= '0;
            cmt_q  <= '0;
            bad_q  <= 1'b0;
        end else if (wr_valid && wr_last) begin
            if (commit_ok) begin
                spec_q <= spec_q + 1'b1;
                cmt_q  <= spec_q + 1'b1;
            end else begin
                spec_q <= cmt_q;
            end
            bad_q <= 1'b0;
        end else if (wr_valid) begin
            if (!room || wr_err) begin
                bad_q <= 1'b1;
            end
            if (we) begin
                spec_q <= spec_q + 1'b1;
            end
        end
    end

    assign waddr    = spec_q[AW-1:0];
    assign spec_ptr = spec_q;
    assign cmt_ptr  = cmt_q;
endmodule

// File: rtl/ptx_rd_ctrl.sv
// Module: read-side transaction control. Keeps a speculative fetch pointer
// and a committed read head. Ack copies fetch to head; nack copies head to
// fetch and wins over both ack and a pop in the same cycle.
// Assumes: wr_cmt is the committed write pointer from the write side.
module ptx_rd_ctrl #(
    parameter  int DEPTH = 2048,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_ready,
    input  logic          rd_ack,
    input  logic          rd_nack,
    input  logic [PW-1:0] wr_cmt,
    output logic          avail,
    output logic [AW-1:0] raddr,
    output logic [PW-1:0] spec_ptr,
    output logic [PW-1:0] head_ptr
);
    logic [PW-1:0] spec_q, head_q;

    // Purpose: data is readable only below the committed write pointer.
    assign avail = (spec_q != wr_cmt);

    // Purpose: move the fetch pointer on pops, rewind it on nack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spec_q <= '0;
        end else if (rd_nack) begin
            spec_q <= head_q;
        end else if (rd_ready && avail) begin
            spec_q <= spec_q + 1'b1;
        end
    end

    // Purpose: release delivered bytes on ack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
        end else if (rd_ack && !rd_nack) begin
            head_q <= spec_q;
        end
    end

    assign raddr    = spec_q[AW-1:0];
    assign spec_ptr = spec_q;
    assign head_ptr = head_q;
endmodule

// File: rtl/pkt_txn_fifo.sv
// Module: top of the transactional packet FIFO. Joins the write control,
// read control and storage, applies the framing mode to the frame marker
// and reports occupancy. Assumes DEPTH is a power of two.
module pkt_txn_fifo #(
    parameter  int DEPTH = 2048,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pack_mode,
    input  logic          wr_valid,
    input  logic [7:0]    wr_data,
    input  logic          wr_last,
    input  logic          wr_err,
    input  logic          wr_frame_end,
    input  logic          rd_ready,
    input  logic          rd_ack,
    input  logic          rd_nack,
    output logic          rd_valid,
    output logic [7:0]    rd_data,
    output logic          rd_last,
    output logic          rd_frame_end,
    output logic [PW-1:0] fill_level,
    output logic [PW-1:0] free_space
);
    logic                we;
    logic [AW-1:0]       waddr, raddr;
    logic [PW-1:0]       wr_spec_ptr, wr_cmt_ptr, rd_spec_ptr, rd_head_ptr;
    ptx_pkg::ptx_entry_t wentry, rentry;

    // Purpose: build the stored entry; one-frame mode ties frame end to packet end.
    always_comb begin
        wentry.data    = wr_data;
        wentry.pkt_end = wr_last;
        wentry.frm_end = pack_mode ? (wr_frame_end | wr_last) : wr_last;
    end

    ptx_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_valid (wr_valid),
        .wr_last  (wr_last),
        .wr_err   (wr_err),
        .rd_head  (rd_head_ptr),
        .we       (we),
        .waddr    (waddr),
        .spec_ptr (wr_spec_ptr),
        .cmt_ptr  (wr_cmt_ptr),
        .free_cnt (free_space)
    );

    ptx_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_ready (rd_ready),
        .rd_ack   (rd_ack),
        .rd_nack  (rd_nack),
        .wr_cmt   (wr_cmt_ptr),
        .avail    (rd_valid),
        .raddr    (raddr),
        .spec_ptr (rd_spec_ptr),
        .head_ptr (rd_head_ptr)
    );

    ptx_store #(.DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wentry),
        .raddr (raddr),
        .rdata (rentry)
    );

    // Purpose: present the fetched entry and committed occupancy.
    always_comb begin
        rd_data      = rentry.data;
        rd_last      = rentry.pkt_end;
        rd_frame_end = rentry.frm_end;
        fill_level   = wr_cmt_ptr - rd_head_ptr;
    end
endmodule

// File: rtl/ptx_chk.sv
// Module: assertion checker for pkt_txn_fifo, attached with bind.
// Relates the pointers driven by the write and read controls over time.
module ptx_chk #(
    parameter  int DEPTH = 2048,
    localparam int AW    = $clog2(DEPTH),
    localparam int PW    = AW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_valid,
    input logic          wr_last,
    input logic          wr_err,
    input logic          rd_ack,
    input logic          rd_nack,
    input logic [PW-1:0] wr_spec,
    input logic [PW-1:0] wr_cmt,
    input logic [PW-1:0] rd_spec,
    input logic [PW-1:0] rd_head
);
    logic [PW-1:0] span_wr, span_rd, span_cm;
    assign span_wr = wr_spec - rd_head;
    assign span_rd = rd_spec - rd_head;
    assign span_cm = wr_cmt - rd_head;

    assert_cmt_on_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_valid && wr_last) |=> $stable(wr_cmt));

    assert_fetch_below_cmt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        span_rd <= span_cm);

    assert_err_rewind_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_last && wr_err) |=> (wr_spec == $past(wr_cmt)) && $stable(wr_cmt));

    assert_ack_moves_head_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack && !rd_nack) |=> (rd_head == $past(rd_spec)));

    assert_nack_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_nack |=> (rd_spec == $past(rd_head)));

    assert_no_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        span_wr <= PW'(DEPTH));

    assert_nack_holds_head_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ack || rd_nack) |=> $stable(rd_head));
endmodule

bind pkt_txn_fifo ptx_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_last  (wr_last),
    .wr_err   (wr_err),
    .rd_ack   (rd_ack),
    .rd_nack  (rd_nack),
    .wr_spec  (wr_spec_ptr),
    .wr_cmt   (wr_cmt_ptr),
    .rd_spec  (rd_spec_ptr),
    .rd_head  (rd_head_ptr)
);

// File: tb/pkt_txn_fifo_tb.sv
// Bench: sweeps packet lengths, error positions, space limits and framing
// modes on a 16-byte FIFO against a queue model of committed bytes.
module pkt_txn_fifo_tb;
    localparam int DEPTH = 16;
    localparam int PW    = $clog2(DEPTH) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pack_mode = 1'b0;
    logic wr_valid = 1'b0, wr_last = 1'b0, wr_err = 1'b0, wr_frame_end = 1'b0;
    logic [7:0] wr_data = '0;
    logic rd_ready = 1'b0, rd_ack = 1'b0, rd_nack = 1'b0;
    logic rd_valid, rd_last, rd_frame_end;
    logic [7:0] rd_data;
    logic [PW-1:0] fill_level, free_space;

    int n_run = 0;
    int n_fail = 0;
    logic [9:0] mq[$];   // {pkt_end, frm_end, data} from head onwards
    int roff = 0;        // model fetch offset from head

    always #10 clk = ~clk;   // 50 MHz

    pkt_txn_fifo #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .pack_mode(pack_mode),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last),
        .wr_err(wr_err), .wr_frame_end(wr_frame_end),
        .rd_ready(rd_ready), .rd_ack(rd_ack), .rd_nack(rd_nack),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
        .rd_frame_end(rd_frame_end), .fill_level(fill_level),
        .free_space(free_space)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_levels(input string req);
        chk(int'(fill_level) == mq.size(), req, int'(fill_level), mq.size());
        chk(int'(free_space) == DEPTH - mq.size(), req, int'(free_space), DEPTH - mq.size());
    endtask

    // Write one packet; err_at < 0 means clean. fe_mask bit i = frame end on byte i.
    task automatic wr_pkt(input int len, input int err_at, input int fe_mask, input int seed);
        int room;
        bit keep;
        room = DEPTH - mq.size();
        for (int i = 0; i < len; i++) begin
            if (i > 0) chk(rd_valid == (mq.size() > roff), "R3", int'(rd_valid), int'(mq.size() > roff));
            wr_valid     = 1'b1;
            wr_data      = 8'(seed + i * 7);
            wr_last      = (i == len - 1);
            wr_err       = (i == err_at);
            wr_frame_end = ((fe_mask >> i) & 1) != 0;
            @(negedge clk);
        end
        wr_valid = 1'b0; wr_last = 1'b0; wr_err = 1'b0; wr_frame_end = 1'b0;
        keep = (err_at < 0) && (len <= room);
        if (keep) begin
            for (int i = 0; i < len; i++) begin
                bit lst, fe;
                lst = (i == len - 1);
                fe  = pack_mode ? (lst || (((fe_mask >> i) & 1) != 0)) : lst;
                mq.push_back({lst, fe, 8'(seed + i * 7)});
            end
        end
        chk_levels(err_at >= 0 ? "R4" : (len > room ? "R5" : "R2"));
    endtask

    task automatic rd_bytes(input int n, input string fe_req);
        for (int k = 0; k < n; k++) begin
            logic [9:0] e;
            if (roff >= mq.size()) begin
                chk(rd_valid == 1'b0, "R3", int'(rd_valid), 0);
                return;
            end
            e = mq[roff];
            chk(rd_valid == 1'b1, "R2", int'(rd_valid), 1);
            chk(rd_data == e[7:0], "R2", int'(rd_data), int'(e[7:0]));
            chk(rd_last == e[9], "R2", int'(rd_last), int'(e[9]));
            chk(rd_frame_end == e[8], fe_req, int'(rd_frame_end), int'(e[8]));
            rd_ready = 1'b1;
            @(negedge clk);
            rd_ready = 1'b0;
            roff++;
        end
    endtask

    task automatic do_ack();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        repeat (roff) void'(mq.pop_front());
        roff = 0;
        chk_levels("R6");
    endtask

    task automatic do_nack();
        int f;
        f = mq.size();
        rd_nack = 1'b1;
        @(negedge clk);
        rd_nack = 1'b0;
        roff = 0;
        chk(int'(fill_level) == f, "R7", int'(fill_level), f);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(fill_level == '0, "R1", int'(fill_level), 0);
        chk(int'(free_space) == DEPTH, "R1", int'(free_space), DEPTH);
        chk(rd_valid == 1'b0, "R1", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: one-frame mode ignores wr_frame_end
        pack_mode = 1'b0;
        wr_pkt(5, -1, 'h1F, 8'h10);
        rd_bytes(5, "R9");
        do_ack();

        // R10: packed mode passes frame ends through
        pack_mode = 1'b1;
        wr_pkt(6, -1, 'h0A, 8'h40);
        rd_bytes(6, "R10");
        do_ack();
        pack_mode = 1'b0;

        // R4: error on every beat of short packets
        for (int len = 1; len <= 6; len++) begin
            for (int e = 0; e < len; e++) begin
                wr_pkt(len, e, 0, 8'h80 + len);
                chk(rd_valid == 1'b0, "R4", int'(rd_valid), 0);
            end
        end

        // R5: oversized packet dropped, exact fit kept
        wr_pkt(DEPTH + 4, -1, 0, 8'h21);
        chk(rd_valid == 1'b0, "R5", int'(rd_valid), 0);
        wr_pkt(DEPTH, -1, 0, 8'h33);
        chk(free_space == '0, "R5", int'(free_space), 0);

        // R8: unacknowledged bytes keep their space
        rd_bytes(DEPTH, "R9");
        chk(free_space == '0, "R8", int'(free_space), 0);
        wr_pkt(1, -1, 0, 8'h55);
        chk(rd_valid == 1'b0, "R8", int'(rd_valid), 0);
        do_ack();

        // R11: ack and nack together -> nack wins
        wr_pkt(4, -1, 0, 8'h60);
        rd_bytes(2, "R9");
        rd_ack = 1'b1; rd_nack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0; rd_nack = 1'b0;
        roff = 0;
        chk(int'(fill_level) == 4, "R11", int'(fill_level), 4);
        chk(rd_data == mq[0][7:0], "R11", int'(rd_data), int'(mq[0][7:0]));
        rd_bytes(4, "R9");
        do_ack();

        // R7/R6: every length, partial read, rewind, full reread, ack
        for (int len = 1; len <= DEPTH; len++) begin
            wr_pkt(len, -1, 0, len * 13);
            rd_bytes((len + 1) / 2, "R9");
            do_nack();
            rd_bytes(len, "R7");
            chk(rd_valid == 1'b0, "R3", int'(rd_valid), 0);
            do_ack();
        end

        // R10 sweep over frame-end positions in packed mode
        pack_mode = 1'b1;
        for (int m = 0; m < 8; m++) begin
            wr_pkt(4, -1, m, 8'hC0 + m);
            rd_bytes(4, "R10");
            do_ack();
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_run++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule